// File: doc/BRIEF.md
# Programmable Parallel I/O Port Controller

This block hangs three byte-wide general-purpose I/O ports off a simple microprocessor bus. The bus has a chip select, read and write strobes (all active low), two address bits and separate 8-bit write and read data paths with a read-data enable. Ports A and B each have one direction for the whole byte. Port C is split into an upper and a lower nibble, and each nibble has its own direction. Every pin is modelled as a separate input, output value and output enable, so the pad ring outside the block does the tri-stating.

Software programs the directions by writing a configuration byte to the control address. The same address also takes single-bit set/clear commands for port C, which lets firmware toggle one port C line without a read-modify-write. Every configuration write clears the output latches. A port A read always returns what is on the pins. A port B or port C read returns the output latch for any group driven as an output. The address and chip select are captured when a strobe goes active, so glitches on them later in the cycle have no effect.

All bus inputs are treated as synchronous to `clk`. Strobe edges are found by comparing each strobe with its value one cycle earlier.

Top module: `pio_ctrl`

## Requirements
- R1: After reset every output enable is 0, every output latch is 0, and all four direction groups are inputs. `rdata_oe` is 0.
- R2: A write to address 3 with data bit 7 = 1 is a configuration byte. Bit 4 sets port A, bit 3 the port C upper nibble, bit 1 port B and bit 0 the port C lower nibble. A 1 means input and a 0 means output. A group's output enables are all 1 when it is an output and all 0 when it is an input. Bits 6, 5 and 2 are ignored.
- R3: Every configuration-byte write clears the output latches of ports A, B and C, even when the directions do not change.
- R4: A write to address 3 with data bit 7 = 0 is a port C bit command. Bits 3:1 select the bit and bit 0 gives its new value. Only that one latch bit changes, and all directions stay as they were.
- R5: A read of address 0 returns the sampled port A pins, even when port A is an output.
- R6: A read of address 1 (port B) or address 2 (port C) returns, for each direction group, the output latch when the group is an output and the sampled pins when it is an input.
- R7: The read address is captured on the cycle the read strobe is first seen low. Changing `addr` while the strobe stays low does not change which register is read.
- R8: If chip select was active when the read strobe fell, the read stays active until the read strobe rises, even if chip select goes inactive first.
- R9: A read of address 3 returns 8'hFF.
- R10: `rdata_oe` rises one clock after the read strobe is first seen low, and only if chip select was active on that cycle. It falls one clock after the read strobe is seen high.
- R11: A write whose chip select was inactive when the write strobe fell has no effect, even if chip select becomes active before the strobe rises.
- R12: Data written to address 0, 1 or 2 is loaded into that port's whole output latch on the clock after the write strobe rises. The latch drives the port's output value pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register address (0 A, 1 B, 2 C, 3 control) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| rdata_oe | output | 1 | Read data bus drive enable |
| pa_in | input | 8 | Port A pin input |
| pa_out | output | 8 | Port A output value |
| pa_oe | output | 8 | Port A output enable |
| pb_in | input | 8 | Port B pin input |
| pb_out | output | 8 | Port B output value |
| pb_oe | output | 8 | Port B output enable |
| pc_in | input | 8 | Port C pin input |
| pc_out | output | 8 | Port C output value |
| pc_oe | output | 8 | Port C output enable |

## Verification
The assertions assume that the read and write strobes are never low together and that the bus inputs change away from the rising clock edge. Without these assumptions, the read-hold and single-bit-change properties would describe overlapping transfers that the block does not define. The bench drives every input on the falling clock edge and runs one bus transfer at a time from its tasks, so the strobes never overlap. It also changes pin inputs only between transfers and waits past the pin sampler before it reads.

// File: rtl/pio_pkg.sv
package pio_pkg;

  localparam int PORT_W = 8;
  localparam int NIB_W  = PORT_W / 2;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADR_A   = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_B   = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_C   = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_CTL = 2'd3;

  localparam int CFG_FLAG_BIT = 7;
  localparam int CFG_A_BIT    = 4;
  localparam int CFG_CU_BIT   = 3;
  localparam int CFG_B_BIT    = 1;
  localparam int CFG_CL_BIT   = 0;

  // 1 in a field = group is input
  typedef struct packed {
    logic a_in;
    logic cu_in;
    logic b_in;
    logic cl_in;
  } pio_dir_t;

  localparam pio_dir_t DIR_ALL_IN = '{a_in: 1'b1, cu_in: 1'b1, b_in: 1'b1, cl_in: 1'b1};

  function automatic logic is_cfg_byte(input logic [PORT_W-1:0] d);
    return d[CFG_FLAG_BIT];
  endfunction

  function automatic pio_dir_t decode_dir(input logic [PORT_W-1:0] d);
    pio_dir_t r;
    r.a_in  = d[CFG_A_BIT];
    r.cu_in = d[CFG_CU_BIT];
    r.b_in  = d[CFG_B_BIT];
    r.cl_in = d[CFG_CL_BIT];
    return r;
  endfunction

  // Single-bit set/clear of a latch byte: cmd[3:1] index, cmd[0] value
  function automatic logic [PORT_W-1:0] bit_cmd_apply(input logic [PORT_W-1:0] lat,
                                                      input logic [PORT_W-1:0] cmd);
    logic [PORT_W-1:0] r;
    r = lat;
    r[cmd[3:1]] = cmd[0];
    return r;
  endfunction

  // Pick latch for output group, pins for input group
  function automatic logic [NIB_W-1:0] pick_nib(input logic is_in,
                                                input logic [NIB_W-1:0] lat,
                                                input logic [NIB_W-1:0] pin);
    return is_in ? pin : lat;
  endfunction

  function automatic logic [PORT_W-1:0] group_oe(input logic is_in);
    return is_in ? '0 : '1;
  endfunction

endpackage

// File: rtl/pio_pin_sync.sv
module pio_pin_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_smp
);

  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '1;
          else        chain[s] <= pin_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '1;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign pin_smp = chain[STAGES-1];

endmodule

// File: rtl/pio_bus_if.sv
module pio_bus_if
  import pio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PORT_W-1:0] wdata,
  output logic              rd_active,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_commit,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [PORT_W-1:0] wr_data
);

  logic rd_q, wr_q;
  logic wr_sel;
  logic rd_fall, wr_fall, wr_rise;

  assign rd_fall   = rd_q & ~rd_n;
  assign wr_fall   = wr_q & ~wr_n;
  assign wr_rise   = ~wr_q & wr_n;
  assign wr_commit = wr_rise & wr_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q      <= 1'b1;
      wr_q      <= 1'b1;
      rd_active <= 1'b0;
      rd_addr   <= '0;
      wr_sel    <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      rd_q <= rd_n;
      wr_q <= wr_n;
      // address and select frozen at the strobe's falling edge
      if (rd_fall) begin
        rd_addr   <= addr;
        rd_active <= ~cs_n;
      end else if (rd_n) begin
        rd_active <= 1'b0;
      end
      if (wr_fall) begin
        wr_addr <= addr;
        wr_sel  <= ~cs_n;
      end else if (wr_rise) begin
        wr_sel  <= 1'b0;
      end
      if (!wr_n) wr_data <= wdata;
    end
  end

endmodule

// File: rtl/pio_regs.sv
module pio_regs
  import pio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_commit,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [PORT_W-1:0] wr_data,
  output pio_dir_t          dir,
  output logic [PORT_W-1:0] lat_a,
  output logic [PORT_W-1:0] lat_b,
  output logic [PORT_W-1:0] lat_c,
  output logic              cfg_wr,
  output logic              bit_wr
);

  logic ctl_hit;

  assign ctl_hit = wr_commit && (wr_addr == ADR_CTL);
  assign cfg_wr  = ctl_hit &&  is_cfg_byte(wr_data);
  assign bit_wr  = ctl_hit && !is_cfg_byte(wr_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir   <= DIR_ALL_IN;
      lat_a <= '0;
      lat_b <= '0;
      lat_c <= '0;
    end else if (cfg_wr) begin
      dir   <= decode_dir(wr_data);
      lat_a <= '0;
      lat_b <= '0;
      lat_c <= '0;
    end else if (bit_wr) begin
      lat_c <= bit_cmd_apply(lat_c, wr_data);
    end else if (wr_commit) begin
      unique case (wr_addr)
        ADR_A:   lat_a <= wr_data;
        ADR_B:   lat_b <= wr_data;
        ADR_C:   lat_c <= wr_data;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/pio_read_mux.sv
module pio_read_mux
  import pio_pkg::*;
(
  input  logic [ADDR_W-1:0] rd_addr,
  input  pio_dir_t          dir,
  input  logic [PORT_W-1:0] lat_b,
  input  logic [PORT_W-1:0] lat_c,
  input  logic [PORT_W-1:0] smp_a,
  input  logic [PORT_W-1:0] smp_b,
  input  logic [PORT_W-1:0] smp_c,
  output logic [PORT_W-1:0] rdata
);

  always_comb begin
    unique case (rd_addr)
      ADR_A:   rdata = smp_a;
      ADR_B:   rdata = dir.b_in ? smp_b : lat_b;
      ADR_C:   rdata = {pick_nib(dir.cu_in, lat_c[PORT_W-1:NIB_W], smp_c[PORT_W-1:NIB_W]),
                        pick_nib(dir.cl_in, lat_c[NIB_W-1:0],      smp_c[NIB_W-1:0])};
      default: rdata = '1;
    endcase
  end

endmodule

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       rdata_oe,
  input  logic [7:0] pa_in,
  output logic [7:0] pa_out,
  output logic [7:0] pa_oe,
  input  logic [7:0] pb_in,
  output logic [7:0] pb_out,
  output logic [7:0] pb_oe,
  input  logic [7:0] pc_in,
  output logic [7:0] pc_out,
  output logic [7:0] pc_oe
);

  // named internal events for the checker
  logic              rd_active;
  logic [ADDR_W-1:0] rd_addr;
  logic              wr_commit;
  logic [ADDR_W-1:0] wr_addr;
  logic [PORT_W-1:0] wr_data;
  logic              cfg_wr;
  logic              bit_wr;
  pio_dir_t          dir;
  logic [PORT_W-1:0] lat_a, lat_b, lat_c;
  logic [PORT_W-1:0] smp_a, smp_b, smp_c;

  pio_bus_if i_bus (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata),
    .rd_active(rd_active), .rd_addr(rd_addr),
    .wr_commit(wr_commit), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  pio_regs i_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_commit(wr_commit), .wr_addr(wr_addr), .wr_data(wr_data),
    .dir(dir), .lat_a(lat_a), .lat_b(lat_b), .lat_c(lat_c),
    .cfg_wr(cfg_wr), .bit_wr(bit_wr)
  );

  logic [PORT_W-1:0] pins_in  [3];
  logic [PORT_W-1:0] pins_smp [3];
  assign pins_in[0] = pa_in;
  assign pins_in[1] = pb_in;
  assign pins_in[2] = pc_in;

  generate
    for (genvar p = 0; p < 3; p++) begin : g_sync
      pio_pin_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(pins_in[p]), .pin_smp(pins_smp[p])
      );
    end
  endgenerate

  assign smp_a = pins_smp[0];
  assign smp_b = pins_smp[1];
  assign smp_c = pins_smp[2];

  pio_read_mux i_rmux (
    .rd_addr(rd_addr), .dir(dir),
    .lat_b(lat_b), .lat_c(lat_c),
    .smp_a(smp_a), .smp_b(smp_b), .smp_c(smp_c),
    .rdata(rdata)
  );

  assign rdata_oe = rd_active;

  assign pa_out = lat_a;
  assign pb_out = lat_b;
  assign pc_out = lat_c;
  assign pa_oe  = group_oe(dir.a_in);
  assign pb_oe  = group_oe(dir.b_in);
  assign pc_oe  = {group_oe(dir.cu_in)[PORT_W-1:NIB_W], group_oe(dir.cl_in)[NIB_W-1:0]};

endmodule

// File: rtl/pio_ctrl_chk.sv
module pio_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       rd_n,
  input logic [7:0] rdata,
  input logic       rdata_oe,
  input logic [1:0] rd_addr,
  input logic       cfg_wr,
  input logic       bit_wr,
  input logic [7:0] pa_out,
  input logic [7:0] pb_out,
  input logic [7:0] pc_out,
  input logic [7:0] pa_oe,
  input logic [7:0] pb_oe,
  input logic [7:0] pc_oe
);

  // R2
  oe_group_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_oe == 8'h00 || pa_oe == 8'hFF) && (pb_oe == 8'h00 || pb_oe == 8'hFF) &&
    (pc_oe[7:4] == 4'h0 || pc_oe[7:4] == 4'hF) && (pc_oe[3:0] == 4'h0 || pc_oe[3:0] == 4'hF));

  // R3
  cfg_clears_latches_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00));

  // R4
  bit_cmd_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_wr |=> ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe) &&
                $stable(pa_out) && $stable(pb_out) &&
                $countones(pc_out ^ $past(pc_out)) <= 1));

  // R7
  rd_addr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_oe && !rd_n) |=> $stable(rd_addr));

  // R8
  rd_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_oe && !rd_n) |=> rdata_oe);

  // R9
  ctl_reads_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_oe && rd_addr == 2'd3) |-> rdata == 8'hFF);

  // R10
  oe_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdata_oe) |-> $past(!cs_n && !rd_n));

  // R10
  oe_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdata_oe) |-> $past(rd_n));

endmodule

bind pio_ctrl pio_ctrl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n),
  .rdata(rdata), .rdata_oe(rdata_oe), .rd_addr(rd_addr),
  .cfg_wr(cfg_wr), .bit_wr(bit_wr),
  .pa_out(pa_out), .pb_out(pb_out), .pc_out(pc_out),
  .pa_oe(pa_oe), .pb_oe(pb_oe), .pc_oe(pc_oe)
);

// File: tb/test_pio_ctrl.sv
`timescale 1ns/1ps
module test_pio_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       rdata_oe;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // bench model
  bit         m_a_in, m_b_in, m_cu_in, m_cl_in;
  logic [7:0] m_la, m_lb, m_lc;

  always #2 clk = ~clk;

  pio_ctrl i_pio_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0: return pa_in;
      2'd1: return m_b_in ? pb_in : m_lb;
      2'd2: return {m_cu_in ? pc_in[7:4] : m_lc[7:4], m_cl_in ? pc_in[3:0] : m_lc[3:0]};
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] oe_of(input bit is_in);
    return is_in ? 8'h00 : 8'hFF;
  endfunction

  task automatic model_write(input logic [1:0] a, input logic [7:0] d);
    if (a == 2'd3 && d[7]) begin
      m_a_in = d[4]; m_cu_in = d[3]; m_b_in = d[1]; m_cl_in = d[0];
      m_la = 0; m_lb = 0; m_lc = 0;
    end else if (a == 2'd3) begin
      m_lc[d[3:1]] = d[0];
    end else if (a == 2'd0) m_la = d;
    else if (a == 2'd1) m_lb = d;
    else m_lc = d;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input bit sel_at_fall);
    @(negedge clk); cs_n = ~sel_at_fall; addr = a; wdata = d; wr_n = 1'b0;
    @(negedge clk); cs_n = 1'b0;
    @(negedge clk); wr_n = 1'b1; cs_n = 1'b1;
    @(negedge clk);
    if (sel_at_fall) model_write(a, d);
  endtask

  task automatic check_pins(input string req);
    chk({req, " pa_out"}, pa_out, m_la);
    chk({req, " pb_out"}, pb_out, m_lb);
    chk({req, " pc_out"}, pc_out, m_lc);
    chk({req, " pa_oe"}, pa_oe, oe_of(m_a_in));
    chk({req, " pb_oe"}, pb_oe, oe_of(m_b_in));
    chk({req, " pc_oe"}, pc_oe, {oe_of(m_cu_in)[7:4], oe_of(m_cl_in)[3:0]});
  endtask

  task automatic bus_read(input logic [1:0] a, input string req);
    @(negedge clk); cs_n = 1'b0; addr = a; rd_n = 1'b0;
    @(negedge clk);
    chk({req, " rdata_oe"}, {7'd0, rdata_oe}, 8'd1);
    chk(req, rdata, exp_read(a));
    rd_n = 1'b1; cs_n = 1'b1;
    @(negedge clk);
    chk("R10 oe drop", {7'd0, rdata_oe}, 8'd0);
  endtask

  task automatic set_pins(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    @(negedge clk); pa_in = a; pb_in = b; pc_in = c;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    m_a_in = 1; m_b_in = 1; m_cu_in = 1; m_cl_in = 1;
    m_la = 0; m_lb = 0; m_lc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_pins("R1");
    chk("R1 rdata_oe", {7'd0, rdata_oe}, 8'd0);
    set_pins(8'h3C, 8'hA5, 8'h96);
    bus_read(2'd1, "R6 B input");
    bus_read(2'd3, "R9 ctl");

    // R2 all outputs, then R12 writes
    bus_write(2'd3, 8'h80, 1'b1); check_pins("R2");
    bus_write(2'd0, 8'h11, 1'b1);
    bus_write(2'd1, 8'h22, 1'b1);
    bus_write(2'd2, 8'h33, 1'b1); check_pins("R12");
    bus_read(2'd0, "R5 A pins while output");
    bus_read(2'd1, "R6 B latch");
    bus_read(2'd2, "R6 C latch");

    // R3 same configuration again clears latches
    bus_write(2'd3, 8'h80, 1'b1); check_pins("R3");
    // R4 bit commands
    bus_write(2'd3, 8'h0B, 1'b1); check_pins("R4 set bit5");
    bus_write(2'd3, 8'h01, 1'b1); check_pins("R4 set bit0");
    bus_write(2'd3, 8'h0A, 1'b1); check_pins("R4 clear bit5");
    chk("R4 pc_out", pc_out, 8'h01);

    // R11 select late: ignored
    bus_write(2'd1, 8'hEE, 1'b0); check_pins("R11");
    bus_read(2'd1, "R11 readback");

    // R6 mixed port C nibbles
    bus_write(2'd3, 8'h88, 1'b1);
    bus_write(2'd2, 8'h5A, 1'b1); check_pins("R2 C upper in");
    bus_read(2'd2, "R6 C mixed");

    // R7 address changes during a long read
    @(negedge clk); cs_n = 1'b0; addr = 2'd0; rd_n = 1'b0;
    @(negedge clk); addr = 2'd1;
    @(negedge clk); chk("R7 addr frozen", rdata, pa_in);
    // R8 deselect before strobe ends
    cs_n = 1'b1;
    @(negedge clk); chk("R8 oe held", {7'd0, rdata_oe}, 8'd1);
    chk("R8 data", rdata, pa_in);
    rd_n = 1'b1;
    @(negedge clk); chk("R10 oe drop", {7'd0, rdata_oe}, 8'd0);
    // R10 read without select never drives
    @(negedge clk); cs_n = 1'b1; addr = 2'd0; rd_n = 1'b0;
    @(negedge clk); chk("R10 unselected", {7'd0, rdata_oe}, 8'd0);
    rd_n = 1'b1;

    // random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      logic [7:0] d;
      op = $urandom_range(0, 5);
      d = 8'($urandom);
      case (op)
        0: begin bus_write(2'd3, d | 8'h80, 1'b1); check_pins("R2 R3 rnd cfg"); end
        1: begin bus_write(2'd3, d & 8'h0F, 1'b1); check_pins("R4 rnd bit"); end
        2: begin bus_write(2'($urandom_range(0, 2)), d, 1'b1); check_pins("R12 rnd wr"); end
        3: begin bus_write(2'($urandom_range(0, 3)), d, 1'b0); check_pins("R11 rnd"); end
        4: set_pins(d, 8'($urandom), 8'($urandom));
        default: bus_read(2'($urandom_range(0, 3)), "R5 R6 R9 rnd rd");
      endcase
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule